// File: doc/BRIEF.md
# FIFO Flag Offset Register Programmer

This block owns the two threshold offsets used by a FIFO's almost-empty and almost-full flag logic. It keeps an "empty-side" offset and a "full-side" offset and presents both continuously to a flag generator. The flag comparison and the FIFO storage sit outside it.

During master reset it installs one of eight preset offset pairs. The preset is chosen by a three-bit code made of the load-control pin and two preset-select pins. The level of the load-control pin during master reset also picks how offsets are written afterwards: bit by bit from a serial input, or one word at a time from the parallel data bus. Both methods work on the write clock. On the read clock, the stored offsets can be read back in parallel whichever method is in use. A partial reset sends every sequence back to its start and keeps the offsets and the chosen method.

The write side is a two-state machine: WR_EMPTY_OFS (the next load targets the empty-side offset) and WR_FULL_OFS. The transition "advance" is taken on each parallel word write, or on the last serial bit of an offset. The transition "rewind" returns to WR_EMPTY_OFS on master or partial reset. The readback side has RD_EMPTY_OFS and RD_FULL_OFS. It has the same "advance" transition, taken on every readback, and the same "rewind" transition on either reset.

Top module: `flag_offset_prog`

## Requirements
- R1: On a write clock edge with `mrst` high, both offsets load the value 2^(k+3)-1, where k = {ld, fsel[1], fsel[0]} (k=0 gives 7, k=7 gives 1023). On a read clock edge with `mrst` high, `qout` becomes 0.
- R2: On a write clock edge with `mrst` high, `ser_mode` takes the level of `ld`: 1 selects serial loading and 0 selects parallel loading.
- R3: In parallel mode, each write clock edge with `wen` and `ld` high stores `din`. The first such write after any reset goes to the empty-side offset, the next to the full-side offset, and the targets alternate from then on.
- R4: In parallel mode, `sen` has no effect. Neither `wen` nor `sen` changes an offset unless `ld` is high.
- R5: In serial mode, each write clock edge with `sen` and `ld` high stores `si` into one offset bit, least significant bit first. The first OFS_W bits go to the empty-side offset and the next OFS_W bits to the full-side offset, and the pattern then repeats. Each bit takes effect at the edge that samples it.
- R6: In serial mode, `wen` and `din` have no effect on the offsets.
- R7: On each read clock edge with `ren` and `ld` high, `qout` loads one offset: the empty-side offset first after any reset, then the full-side offset, alternating from then on. At all other times `qout` holds. This works in both loading methods.
- R8: Partial reset (`prst` high, `mrst` low) leaves both offsets, `ser_mode` and `qout` unchanged. It clears the write target, the serial bit position and the readback target back to the empty-side offset.
- R9: A write or readback request on the same edge as a partial reset is dropped; the reset takes priority.
- R10: A readback and a write to the same offset on one shared edge return the value the offset held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, sampled by both clocks |
| prst | input | 1 | Partial reset, active high, sampled by both clocks |
| ld | input | 1 | Load control: chooses preset and method in reset, qualifies writes and readbacks afterwards |
| fsel | input | 2 | Preset select, low two bits of the preset code |
| sen | input | 1 | Serial write enable |
| si | input | 1 | Serial data bit |
| wen | input | 1 | Parallel write enable |
| din | input | OFS_W | Parallel write data |
| ren | input | 1 | Readback enable |
| qout | output | OFS_W | Readback data |
| ae_ofs | output | OFS_W | Empty-side offset to the flag generator |
| af_ofs | output | OFS_W | Full-side offset to the flag generator |
| ser_mode | output | 1 | 1 when serial loading was chosen at master reset |

## Verification
Two kinds of work can meet on one edge. The first case is a write that lands on the same edge as a readback of the same offset. The bench drives both clocks from one source and raises `wen`, `ren` and `ld` together while both targets point at the empty-side offset; it then expects `qout` to show the old value and `ae_ofs` the new one. The second case is a write that lands on the same edge as a partial reset. The bench expects the offsets to stay unchanged and the next write to go to the empty-side offset. A behavioural model follows every edge and compares all outputs after each one.

// File: rtl/fop_pkg.sv
package fop_pkg;

    typedef enum logic {
        WR_EMPTY_OFS = 1'b0,
        WR_FULL_OFS  = 1'b1
    } wr_state_e;

    typedef enum logic {
        RD_EMPTY_OFS = 1'b0,
        RD_FULL_OFS  = 1'b1
    } rd_state_e;

    // Preset threshold for reset code k: 2^(k+3) - 1 (7 .. 1023).
    function automatic logic [31:0] preset_offset(input logic [2:0] code);
        return (32'd1 << (32'(code) + 32'd3)) - 32'd1;
    endfunction

endpackage

// File: rtl/fop_wr_ctrl.sv
module fop_wr_ctrl
    import fop_pkg::*;
#(
    parameter int OFS_W = 10
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             prst,
    input  logic             ld,
    input  logic [1:0]       fsel,
    input  logic             sen,
    input  logic             si,
    input  logic             wen,
    input  logic [OFS_W-1:0] din,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs,
    output logic             ser_mode
);
    localparam int CNT_W = (OFS_W > 1) ? $clog2(OFS_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(OFS_W - 1);

    wr_state_e        st_q, st_d;
    logic [CNT_W-1:0] bit_q, bit_d;
    logic             par_hit, ser_hit, last_bit;
    logic [OFS_W-1:0] preset_val;

    assign preset_val = OFS_W'(preset_offset({ld, fsel}));
    assign par_hit    = !ser_mode && wen && ld;
    assign ser_hit    = ser_mode && sen && ld;
    assign last_bit   = (bit_q == LAST_BIT);

    // next-state: advance on a word write or on the last serial bit
    always_comb begin
        st_d  = st_q;
        bit_d = bit_q;
        unique case (st_q)
            WR_EMPTY_OFS: begin
                if (par_hit) begin
                    st_d = WR_FULL_OFS;
                end else if (ser_hit) begin
                    if (last_bit) begin
                        bit_d = '0;
                        st_d  = WR_FULL_OFS;
                    end else begin
                        bit_d = bit_q + 1'b1;
                    end
                end
            end
            WR_FULL_OFS: begin
                if (par_hit) begin
                    st_d = WR_EMPTY_OFS;
                end else if (ser_hit) begin
                    if (last_bit) begin
                        bit_d = '0;
                        st_d  = WR_EMPTY_OFS;
                    end else begin
                        bit_d = bit_q + 1'b1;
                    end
                end
            end
            default: begin
                st_d  = WR_EMPTY_OFS;
                bit_d = '0;
            end
        endcase
    end

    // state register: rewind on either reset
    always_ff @(posedge clk) begin
        if (mrst || prst) begin
            st_q  <= WR_EMPTY_OFS;
            bit_q <= '0;
        end else begin
            st_q  <= st_d;
            bit_q <= bit_d;
        end
    end

    // offset registers and method
    always_ff @(posedge clk) begin
        if (mrst) begin
            ae_ofs   <= preset_val;
            af_ofs   <= preset_val;
            ser_mode <= ld;
        end else if (!prst) begin
            if (par_hit) begin
                if (st_q == WR_EMPTY_OFS) ae_ofs <= din;
                else                      af_ofs <= din;
            end else if (ser_hit) begin
                if (st_q == WR_EMPTY_OFS) ae_ofs[bit_q] <= si;
                else                      af_ofs[bit_q] <= si;
            end
        end
    end

endmodule

// File: rtl/fop_rd_ctrl.sv
module fop_rd_ctrl
    import fop_pkg::*;
#(
    parameter int OFS_W = 10
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             prst,
    input  logic             ld,
    input  logic             ren,
    input  logic [OFS_W-1:0] ae_ofs,
    input  logic [OFS_W-1:0] af_ofs,
    output logic [OFS_W-1:0] qout
);
    rd_state_e st_q, st_d;
    logic      rd_hit;

    assign rd_hit = ren && ld;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RD_EMPTY_OFS: if (rd_hit) st_d = RD_FULL_OFS;
            RD_FULL_OFS:  if (rd_hit) st_d = RD_EMPTY_OFS;
            default:      st_d = RD_EMPTY_OFS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (mrst || prst) st_q <= RD_EMPTY_OFS;
        else              st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (mrst) begin
            qout <= '0;
        end else if (!prst && rd_hit) begin
            qout <= (st_q == RD_EMPTY_OFS) ? ae_ofs : af_ofs;
        end
    end

endmodule

// File: rtl/flag_offset_prog.sv
module flag_offset_prog #(
    parameter int OFS_W = 10
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             mrst,
    input  logic             prst,
    input  logic             ld,
    input  logic [1:0]       fsel,
    input  logic             sen,
    input  logic             si,
    input  logic             wen,
    input  logic [OFS_W-1:0] din,
    input  logic             ren,
    output logic [OFS_W-1:0] qout,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs,
    output logic             ser_mode
);
    fop_wr_ctrl #(.OFS_W(OFS_W)) u_wr (
        .clk      (wclk),
        .mrst     (mrst),
        .prst     (prst),
        .ld       (ld),
        .fsel     (fsel),
        .sen      (sen),
        .si       (si),
        .wen      (wen),
        .din      (din),
        .ae_ofs   (ae_ofs),
        .af_ofs   (af_ofs),
        .ser_mode (ser_mode)
    );

    fop_rd_ctrl #(.OFS_W(OFS_W)) u_rd (
        .clk    (rclk),
        .mrst   (mrst),
        .prst   (prst),
        .ld     (ld),
        .ren    (ren),
        .ae_ofs (ae_ofs),
        .af_ofs (af_ofs),
        .qout   (qout)
    );

endmodule

// File: rtl/fop_checker.sv
module fop_checker #(
    parameter int OFS_W = 10
) (
    input logic             wclk,
    input logic             rclk,
    input logic             mrst,
    input logic             prst,
    input logic             ld,
    input logic [1:0]       fsel,
    input logic             sen,
    input logic             wen,
    input logic [OFS_W-1:0] din,
    input logic             ren,
    input logic [OFS_W-1:0] qout,
    input logic [OFS_W-1:0] ae_ofs,
    input logic [OFS_W-1:0] af_ofs,
    input logic             ser_mode
);
    logic wr_req;
    assign wr_req = ld && (ser_mode ? sen : wen);

    assert_preset_R1: assert property (@(posedge wclk) disable iff (mrst)
        $past(mrst) |-> (ae_ofs == OFS_W'(fop_pkg::preset_offset({$past(ld), $past(fsel)})))
                     && (af_ofs == ae_ofs));

    assert_method_R2: assert property (@(posedge wclk) disable iff (mrst)
        $past(mrst) |-> (ser_mode == $past(ld)));

    assert_word_store_R3: assert property (@(posedge wclk) disable iff (mrst)
        (!prst && !ser_mode && wen && ld) |=> (ae_ofs == $past(din)) || (af_ofs == $past(din)));

    assert_no_req_stable_R4: assert property (@(posedge wclk) disable iff (mrst)
        (!prst && !wr_req) |=> $stable(ae_ofs) && $stable(af_ofs) && $stable(ser_mode));

    assert_partial_keep_R8: assert property (@(posedge wclk) disable iff (mrst)
        prst |=> $stable(ae_ofs) && $stable(af_ofs) && $stable(ser_mode));

    assert_read_hold_R7: assert property (@(posedge rclk) disable iff (mrst)
        !(ren && ld) |=> $stable(qout));

endmodule

bind flag_offset_prog fop_checker #(.OFS_W(OFS_W)) u_fop_chk (
    .wclk     (wclk),
    .rclk     (rclk),
    .mrst     (mrst),
    .prst     (prst),
    .ld       (ld),
    .fsel     (fsel),
    .sen      (sen),
    .wen      (wen),
    .din      (din),
    .ren      (ren),
    .qout     (qout),
    .ae_ofs   (ae_ofs),
    .af_ofs   (af_ofs),
    .ser_mode (ser_mode)
);

// File: tb/test_flag_offset_prog.sv
module test_flag_offset_prog;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         mrst = 1'b1, prst = 1'b0, ld = 1'b0, sen = 1'b0, si = 1'b0;
    logic         wen = 1'b0, ren = 1'b0;
    logic [1:0]   fsel = 2'b00;
    logic [W-1:0] din = '0;
    logic [W-1:0] qout, ae_ofs, af_ofs;
    logic         ser_mode;

    int    n_checks = 0, n_errors = 0;
    string cur_req = "R1";
    bit    started = 0;
    bit    finished = 0;

    // behavioural reference state
    int m_ae, m_af, m_wp, m_bit, m_rp, m_q;
    bit m_ser;

    always #5 clk = ~clk;

    flag_offset_prog #(.OFS_W(W)) i_flag_offset_prog (
        .wclk(clk), .rclk(clk), .mrst(mrst), .prst(prst), .ld(ld), .fsel(fsel),
        .sen(sen), .si(si), .wen(wen), .din(din), .ren(ren),
        .qout(qout), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .ser_mode(ser_mode)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (mrst) begin
            m_ae  = (1 << ({ld, fsel} + 3)) - 1;
            m_af  = m_ae;
            m_ser = ld;
            m_wp = 0; m_bit = 0; m_rp = 0; m_q = 0;
        end else if (prst) begin
            m_wp = 0; m_bit = 0; m_rp = 0;
        end else begin
            if (ren && ld) begin
                m_q  = (m_rp == 0) ? m_ae : m_af;
                m_rp = 1 - m_rp;
            end
            if (!m_ser && wen && ld) begin
                if (m_wp == 0) m_ae = int'(din); else m_af = int'(din);
                m_wp = 1 - m_wp;
            end
            if (m_ser && sen && ld) begin
                if (m_wp == 0) m_ae = si ? (m_ae | (1 << m_bit)) : (m_ae & ~(1 << m_bit));
                else           m_af = si ? (m_af | (1 << m_bit)) : (m_af & ~(1 << m_bit));
                m_bit++;
                if (m_bit == W) begin m_bit = 0; m_wp = 1 - m_wp; end
            end
        end
        started = 1;
    end

    // per-edge comparison against the model
    always @(posedge clk) begin
        #2;
        if (started && !finished) begin
            check({cur_req, " ae_ofs"}, int'(ae_ofs), m_ae);
            check({cur_req, " af_ofs"}, int'(af_ofs), m_af);
            check({cur_req, " ser_mode"}, int'(ser_mode), int'(m_ser));
            check({cur_req, " qout"}, int'(qout), m_q);
        end
    end

    task automatic idle();
        ld = 0; wen = 0; ren = 0; sen = 0; si = 0; prst = 0; mrst = 0;
    endtask

    task automatic mreset(input logic l, input logic [1:0] fs);
        @(negedge clk); mrst = 1; ld = l; fsel = fs;
        @(negedge clk); idle();
    endtask

    task automatic par_write(input logic [W-1:0] v);
        @(negedge clk); ld = 1; wen = 1; din = v;
        @(negedge clk); idle();
    endtask

    task automatic readback();
        @(negedge clk); ld = 1; ren = 1;
        @(negedge clk); idle();
    endtask

    task automatic shift_bits(input logic [W-1:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ld = 1; sen = 1; si = v[i];
        end
        @(negedge clk); idle();
    endtask

    initial begin
        // R1 / R2: preset code 3 -> 63, parallel method
        cur_req = "R1";
        mreset(1'b0, 2'b11);
        check("R1 preset ae", int'(ae_ofs), 63);
        check("R1 preset af", int'(af_ofs), 63);
        check("R1 qout cleared", int'(qout), 0);
        cur_req = "R2";
        check("R2 parallel chosen", int'(ser_mode), 0);

        cur_req = "R3";
        par_write(10'd100);
        check("R3 first to empty side", int'(ae_ofs), 100);
        par_write(10'd200);
        check("R3 second to full side", int'(af_ofs), 200);

        cur_req = "R4";
        @(negedge clk); ld = 1; sen = 1; si = 1;
        @(negedge clk); ld = 0; sen = 0; wen = 1; din = 10'd77;
        @(negedge clk); idle();
        check("R4 ae unchanged", int'(ae_ofs), 100);
        check("R4 af unchanged", int'(af_ofs), 200);

        cur_req = "R7";
        readback();
        check("R7 readback empty side", int'(qout), 100);
        readback();
        check("R7 readback full side", int'(qout), 200);
        repeat (2) @(negedge clk);
        check("R7 qout holds", int'(qout), 200);

        // R10: same-edge write and readback of the empty-side offset
        cur_req = "R10";
        @(negedge clk); ld = 1; wen = 1; ren = 1; din = 10'd300;
        @(negedge clk); idle();
        check("R10 readback sees old value", int'(qout), 100);
        check("R10 write took effect", int'(ae_ofs), 300);

        // R9 / R8: partial reset with a write on the same edge
        cur_req = "R9";
        @(negedge clk); prst = 1; ld = 1; wen = 1; din = 10'd7;
        @(negedge clk); idle();
        check("R9 write dropped ae", int'(ae_ofs), 300);
        check("R9 write dropped af", int'(af_ofs), 200);
        cur_req = "R8";
        check("R8 method kept", int'(ser_mode), 0);
        par_write(10'd9);
        check("R8 write target rewound", int'(ae_ofs), 9);
        readback();
        check("R8 read target rewound", int'(qout), 9);

        // serial method: preset code 5 -> 255
        cur_req = "R2";
        mreset(1'b1, 2'b01);
        check("R2 serial chosen", int'(ser_mode), 1);
        check("R1 preset code 5", int'(ae_ofs), 255);

        cur_req = "R5";
        shift_bits(10'h2A5, W);
        check("R5 empty side shifted", int'(ae_ofs), 'h2A5);
        shift_bits(10'h15A, W);
        check("R5 full side shifted", int'(af_ofs), 'h15A);

        cur_req = "R8";
        shift_bits(10'h00F, 4);
        check("R5 partial bits applied", int'(ae_ofs), 'h2AF);
        @(negedge clk); prst = 1;
        @(negedge clk); idle();
        check("R8 offset kept", int'(ae_ofs), 'h2AF);
        check("R8 serial kept", int'(ser_mode), 1);
        shift_bits(10'h0F0, W);
        shift_bits(10'h3C3, W);
        check("R8 bit position rewound ae", int'(ae_ofs), 'h0F0);
        check("R8 bit position rewound af", int'(af_ofs), 'h3C3);

        cur_req = "R6";
        par_write(10'd0);
        check("R6 word write ignored", int'(ae_ofs), 'h0F0);

        cur_req = "R7";
        readback();
        check("R7 serial readback empty", int'(qout), 'h0F0);
        readback();
        check("R7 serial readback full", int'(qout), 'h3C3);

        cur_req = "R1";
        mreset(1'b1, 2'b11);
        check("R1 preset code 7", int'(af_ofs), 1023);
        mreset(1'b0, 2'b00);
        check("R1 preset code 0", int'(ae_ofs), 7);
        check("R1 qout cleared again", int'(qout), 0);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule